// File: doc/BRIEF.md
# SIMD Branch and Loop Control Unit

This unit sequences flow control for a small group of pixels that run one instruction stream in lockstep. Each pixel keeps an active flag and a branch-depth counter. When a flow-control instruction is presented, the unit does four things. It collects a jump wish from every voting pixel and decides whether the group jumps. It computes the next program counter. It updates each pixel's divergence state. It maintains two small stacks: one for call and return addresses and one for loop counts and the loop register.

Each pixel's wish is one bit of an 8-entry truth table. The table is indexed by that pixel's ALU-result bit, its predicate bit and a static boolean shared by the group. The wishes are combined by an all-vote or an any-vote. A taken jump and a not-taken jump each carry their own branch-state operation, so if/else/endif nesting can be expressed with counters and no per-level mask storage. Instruction fetch and the arithmetic datapath are outside this unit.

Results are registered. They appear one cycle after `fc_valid`, together with the updated active mask and the current loop register.

Top module: `simd_flow_ctl`

## Requirements
- R1: After reset every pixel is active with a zero counter. Both stacks are empty, the error flag is clear, `loop_reg` reads 0, and `res_valid`, `jump_taken` and `pc_next` are 0.
- R2: A pixel's wish is `jump_tbl[{alu_bits[i], pred_bits[i], static_bool}]`. With `any_mode`=0 a plain jump (`fc_op` 0, and also the unused codes 5 to 7) is taken only if every voting pixel wishes. If no pixel votes, it is taken.
- R3: With `any_mode`=1 the jump is taken if at least one voting pixel wishes. If no pixel votes, it is not taken.
- R4: The voters are the active pixels. When `ignore_uncov`=1, only active pixels whose `covered` bit is set vote.
- R5: The branch-state operation is `bs_taken` when the jump is taken and `bs_not_taken` when it is not. The codes are 0 = none, 1 = decrement, 2 = increment, 3 = none. Increment adds 1 to each inactive pixel's counter, saturating at its maximum. It also makes inactive, with counter 0, every active pixel whose wish differs from the outcome.
- R6: Decrement subtracts `pop_cnt` from each inactive pixel's counter. A pixel whose result would fall below zero becomes active with counter 0. Active pixels are untouched.
- R7: When `else_flag`=1 the following swap happens before voting. Active pixels become inactive with counter 0, and inactive pixels with counter 0 become active.
- R8: The result appears one cycle after `fc_valid`. When the jump is not taken, `pc_next` = `cur_pc`+1 (modulo 2^PC_W). When it is taken, `pc_next` = `jump_addr` if `jump_global`=1, and otherwise `jump_addr`+`prog_offset` (modulo 2^PC_W).
- R9: `stk_op` acts only on a taken jump, with codes 0 = none, 1 = pop, 2 = push. Push saves `cur_pc`. Pop makes the popped address the next program counter.
- R10: LOOP (`fc_op` 1) and REP (`fc_op` 3) always jump when `loop_count` is 0, and otherwise jump on the vote. When not taken, they push {`loop_count`, loop register}. LOOP pushes `loop_base` as the loop register. REP copies the current loop register, which is 0 when the loop stack is empty.
- R11: ENDLOOP (`fc_op` 2) and ENDREP (`fc_op` 4) decrement the top count. ENDLOOP also increments the top loop register. They jump on the vote only while the new count is non-zero. When the new count reaches zero, the entry is popped. `loop_reg` shows the top loop register, or 0 when the loop stack is empty.
- R12: Each stack holds STK_DEPTH entries. A push to a full stack, a pop from an empty address stack, or an ENDLOOP/ENDREP on an empty loop stack sets the sticky `stack_err` and leaves the stack unchanged. An address pop that fails jumps to the computed target. An ENDLOOP/ENDREP that fails is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_valid | input | 1 | A flow-control instruction is presented this cycle |
| fc_op | input | 3 | 0 jump, 1 loop, 2 endloop, 3 rep, 4 endrep |
| jump_tbl | input | 8 | Jump truth table indexed by {alu, pred, bool} |
| any_mode | input | 1 | 1 = any-vote, 0 = all-vote |
| bs_taken | input | 2 | Branch-state operation applied when taken |
| bs_not_taken | input | 2 | Branch-state operation applied when not taken |
| pop_cnt | input | POP_W | Amount subtracted by the decrement operation |
| else_flag | input | 1 | Swap active and zero-depth inactive pixels first |
| stk_op | input | 2 | Address stack operation on a taken jump |
| ignore_uncov | input | 1 | Exclude uncovered pixels from the vote |
| jump_addr | input | PC_W | Jump address field |
| jump_global | input | 1 | Use jump_addr without the program offset |
| prog_offset | input | PC_W | Program offset added to non-global targets |
| cur_pc | input | PC_W | Address of the current instruction |
| alu_bits | input | NPIX | Per-pixel ALU-result bits |
| pred_bits | input | NPIX | Per-pixel predicate bits |
| static_bool | input | 1 | Static boolean shared by the group |
| covered | input | NPIX | Per-pixel coverage mask |
| loop_count | input | LCNT_W | Static iteration count for loop/rep |
| loop_base | input | LREG_W | Initial loop register value for loop |
| res_valid | output | 1 | Result registers updated last cycle |
| jump_taken | output | 1 | The jump was taken |
| pc_next | output | PC_W | Next program counter |
| active_mask | output | NPIX | Current per-pixel active flags |
| loop_reg | output | LREG_W | Loop register at the top of the loop stack |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench drives the group into divergence and back. It does so with increment and decrement sequences whose counter values are visible only through the instant at which each pixel reactivates. A design that decremented active pixels, or that treated a zero result as negative, would reactivate pixels a step early or late. It also covers the empty-vote cases in both vote modes, the else swap, target wrap-around, and a REP nested inside a LOOP. In that nesting, a design that clobbered the outer loop register or popped on the wrong iteration would show a wrong `loop_reg` or a wrong jump. Finally, a fifth push and the pops after it show whether an overflowing push corrupted the saved addresses.

// File: rtl/simd_fc_pkg.sv
package simd_fc_pkg;

    typedef enum logic [2:0] {
        OP_JUMP    = 3'd0,
        OP_LOOP    = 3'd1,
        OP_ENDLOOP = 3'd2,
        OP_REP     = 3'd3,
        OP_ENDREP  = 3'd4
    } fc_op_e;

    typedef enum logic [1:0] {
        BS_NONE = 2'd0,
        BS_DEC  = 2'd1,
        BS_INC  = 2'd2
    } bs_op_e;

    typedef enum logic [1:0] {
        STK_NONE = 2'd0,
        STK_POP  = 2'd1,
        STK_PUSH = 2'd2
    } stk_op_e;

endpackage

// File: rtl/simd_fc_lane.sv
module simd_fc_lane #(
    parameter int CNT_W = 8,
    parameter int POP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             else_flag,
    input  logic [7:0]       jump_tbl,
    input  logic             alu_bit,
    input  logic             pred_bit,
    input  logic             static_bool,
    input  logic             take,
    input  logic [1:0]       bs_op,
    input  logic [POP_W-1:0] pop_cnt,
    output logic             act_pre,
    output logic             wish,
    output logic             active
);
    import simd_fc_pkg::*;

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } lane_t;

    lane_t q, d, sw;
    logic [CNT_W:0] diff;

    // else swap happens before the vote
    always_comb begin
        sw = q;
        if (fire && else_flag) begin
            if (q.act) begin
                sw.act = 1'b0;
                sw.cnt = '0;
            end else if (q.cnt == '0) begin
                sw.act = 1'b1;
            end
        end
        act_pre = sw.act;
        wish    = jump_tbl[{alu_bit, pred_bit, static_bool}];
    end

    always_comb begin
        d    = sw;
        diff = {1'b0, sw.cnt} - (CNT_W + 1)'(pop_cnt);
        if (fire) begin
            case (bs_op_e'(bs_op))
                BS_INC: begin
                    if (!sw.act) begin
                        if (sw.cnt != '1) d.cnt = sw.cnt + 1'b1;
                    end else if (wish != take) begin
                        d.act = 1'b0;
                        d.cnt = '0;
                    end
                end
                BS_DEC: begin
                    if (!sw.act) begin
                        if (diff[CNT_W]) begin
                            d.act = 1'b1;
                            d.cnt = '0;
                        end else begin
                            d.cnt = diff[CNT_W-1:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.act <= 1'b1;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = q.act;

endmodule

// File: rtl/simd_fc_lifo.sv
module simd_fc_lifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         upd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] udata,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int CB = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CB-1:0]           cnt;
    } stk_t;

    stk_t q, d;
    logic [CB-1:0] cm1;

    always_comb begin
        d     = q;
        empty = (q.cnt == '0);
        full  = (q.cnt == CB'(DEPTH));
        cm1   = q.cnt - 1'b1;
        top   = empty ? '0 : q.mem[IW'(cm1)];
        if (push && !full) begin
            d.mem[IW'(q.cnt)] = wdata;
            d.cnt = q.cnt + 1'b1;
        end else if (pop && !empty) begin
            d.cnt = cm1;
        end else if (upd && !empty) begin
            d.mem[IW'(cm1)] = udata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/simd_flow_ctl.sv
module simd_flow_ctl #(
    parameter int NPIX      = 4,
    parameter int PC_W      = 9,
    parameter int CNT_W     = 8,
    parameter int POP_W     = 5,
    parameter int LCNT_W    = 8,
    parameter int LREG_W    = 8,
    parameter int STK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_valid,
    input  logic [2:0]        fc_op,
    input  logic [7:0]        jump_tbl,
    input  logic              any_mode,
    input  logic [1:0]        bs_taken,
    input  logic [1:0]        bs_not_taken,
    input  logic [POP_W-1:0]  pop_cnt,
    input  logic              else_flag,
    input  logic [1:0]        stk_op,
    input  logic              ignore_uncov,
    input  logic [PC_W-1:0]   jump_addr,
    input  logic              jump_global,
    input  logic [PC_W-1:0]   prog_offset,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [NPIX-1:0]   alu_bits,
    input  logic [NPIX-1:0]   pred_bits,
    input  logic              static_bool,
    input  logic [NPIX-1:0]   covered,
    input  logic [LCNT_W-1:0] loop_count,
    input  logic [LREG_W-1:0] loop_base,
    output logic              res_valid,
    output logic              jump_taken,
    output logic [PC_W-1:0]   pc_next,
    output logic [NPIX-1:0]   active_mask,
    output logic [LREG_W-1:0] loop_reg,
    output logic              stack_err
);
    import simd_fc_pkg::*;

    localparam int LW = LCNT_W + LREG_W;

    typedef struct packed {
        logic            res_valid;
        logic            taken;
        logic [PC_W-1:0] pc;
        logic            err;
    } ctl_t;

    ctl_t q, d;

    logic [NPIX-1:0]   act_pre, wish, voters;
    logic              any_yes, all_yes, vote, take, err_ev;
    logic [1:0]        bs_sel;
    logic [PC_W-1:0]   target, pc_calc;
    logic [LREG_W-1:0] cur_al;
    logic [LCNT_W-1:0] dec_cnt;
    fc_op_e            op;

    logic [LW-1:0]     ltop, lwdata, ludata;
    logic              lpush, lpop, lupd, lempty, lfull;
    logic              lpush_c, lpop_c, lupd_c;
    logic [PC_W-1:0]   atop;
    logic              apush, apop, aempty, afull;
    logic              apush_c, apop_c;

    always_comb begin
        op      = fc_op_e'(fc_op);
        voters  = act_pre & (ignore_uncov ? covered : {NPIX{1'b1}});
        any_yes = |(voters & wish);
        all_yes = &(~voters | wish);
        vote    = any_mode ? any_yes : all_yes;
        cur_al  = lempty ? '0 : ltop[LREG_W-1:0];
        dec_cnt = ltop[LW-1:LREG_W] - 1'b1;
        target  = jump_global ? jump_addr : jump_addr + prog_offset;
        lwdata  = {loop_count, (op == OP_LOOP) ? loop_base : cur_al};
        ludata  = {dec_cnt, (op == OP_ENDLOOP) ? cur_al + 1'b1 : cur_al};
        take    = vote;
        err_ev  = 1'b0;
        lpush_c = 1'b0;
        lpop_c  = 1'b0;
        lupd_c  = 1'b0;
        apush_c = 1'b0;
        apop_c  = 1'b0;

        case (op)
            OP_LOOP, OP_REP: begin
                take = (loop_count == '0) | vote;
                if (!take) begin
                    if (lfull) err_ev  = 1'b1;
                    else       lpush_c = 1'b1;
                end
            end
            OP_ENDLOOP, OP_ENDREP: begin
                if (lempty) begin
                    take   = 1'b0;
                    err_ev = 1'b1;
                end else begin
                    take = vote && (dec_cnt != '0);
                    if (dec_cnt == '0) lpop_c = 1'b1;
                    else               lupd_c = 1'b1;
                end
            end
            default: ;
        endcase

        if (take && stk_op_e'(stk_op) == STK_PUSH) begin
            if (afull) err_ev  = 1'b1;
            else       apush_c = 1'b1;
        end
        if (take && stk_op_e'(stk_op) == STK_POP) begin
            if (aempty) begin
                err_ev = 1'b1;
            end else begin
                target = atop;
                apop_c = 1'b1;
            end
        end

        pc_calc = take ? target : cur_pc + 1'b1;
        bs_sel  = take ? bs_taken : bs_not_taken;

        lpush = fc_valid & lpush_c;
        lpop  = fc_valid & lpop_c;
        lupd  = fc_valid & lupd_c;
        apush = fc_valid & apush_c;
        apop  = fc_valid & apop_c;

        d           = q;
        d.res_valid = fc_valid;
        if (fc_valid) begin
            d.taken = take;
            d.pc    = pc_calc;
            d.err   = q.err | err_ev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < NPIX; i++) begin : g_lane
        simd_fc_lane #(.CNT_W(CNT_W), .POP_W(POP_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (fc_valid),
            .else_flag  (else_flag),
            .jump_tbl   (jump_tbl),
            .alu_bit    (alu_bits[i]),
            .pred_bit   (pred_bits[i]),
            .static_bool(static_bool),
            .take       (take),
            .bs_op      (bs_sel),
            .pop_cnt    (pop_cnt),
            .act_pre    (act_pre[i]),
            .wish       (wish[i]),
            .active     (active_mask[i])
        );
    end

    simd_fc_lifo #(.W(PC_W), .DEPTH(STK_DEPTH)) u_addr_stk (
        .clk(clk), .rst_n(rst_n), .push(apush), .pop(apop), .upd(1'b0),
        .wdata(cur_pc), .udata('0), .top(atop), .empty(aempty), .full(afull)
    );

    simd_fc_lifo #(.W(LW), .DEPTH(STK_DEPTH)) u_loop_stk (
        .clk(clk), .rst_n(rst_n), .push(lpush), .pop(lpop), .upd(lupd),
        .wdata(lwdata), .udata(ludata), .top(ltop), .empty(lempty), .full(lfull)
    );

    assign res_valid  = q.res_valid;
    assign jump_taken = q.taken;
    assign pc_next    = q.pc;
    assign stack_err  = q.err;
    assign loop_reg   = cur_al;

endmodule

// File: rtl/simd_flow_ctl_chk.sv
module simd_flow_ctl_chk #(
    parameter int NPIX   = 4,
    parameter int PC_W   = 9,
    parameter int LCNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fc_valid,
    input logic [2:0]        fc_op,
    input logic              any_mode,
    input logic              else_flag,
    input logic              ignore_uncov,
    input logic [NPIX-1:0]   covered,
    input logic [LCNT_W-1:0] loop_count,
    input logic              jump_global,
    input logic [PC_W-1:0]   jump_addr,
    input logic [PC_W-1:0]   cur_pc,
    input logic [1:0]        stk_op,
    input logic              res_valid,
    input logic              jump_taken,
    input logic [PC_W-1:0]   pc_next,
    input logic [NPIX-1:0]   active_mask,
    input logic              stack_err
);
    logic [NPIX-1:0] voters;
    assign voters = ignore_uncov ? (active_mask & covered) : active_mask;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fc_valid |=> res_valid);

    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_valid |=> !res_valid);

    // R8
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !jump_taken) |-> (pc_next == PC_W'($past(cur_pc) + 1'b1)));

    // R8
    global_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && jump_taken && $past(jump_global) && $past(stk_op) != 2'd1)
        |-> (pc_next == $past(jump_addr)));

    // R2
    all_empty_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_valid && fc_op == 3'd0 && !any_mode && !else_flag && voters == '0)
        |=> jump_taken);

    // R3
    any_empty_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_valid && fc_op == 3'd0 && any_mode && !else_flag && voters == '0)
        |=> !jump_taken);

    // R10
    loop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_valid && fc_op == 3'd1 && loop_count == '0) |=> jump_taken);

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

endmodule

bind simd_flow_ctl simd_flow_ctl_chk #(
    .NPIX(NPIX), .PC_W(PC_W), .LCNT_W(LCNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fc_valid(fc_valid), .fc_op(fc_op),
    .any_mode(any_mode), .else_flag(else_flag), .ignore_uncov(ignore_uncov),
    .covered(covered), .loop_count(loop_count), .jump_global(jump_global),
    .jump_addr(jump_addr), .cur_pc(cur_pc), .stk_op(stk_op),
    .res_valid(res_valid), .jump_taken(jump_taken), .pc_next(pc_next),
    .active_mask(active_mask), .stack_err(stack_err)
);

// File: tb/sim_simd_flow_ctl.sv
module sim_simd_flow_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fc_valid;
    logic [2:0] fc_op;
    logic [7:0] jump_tbl;
    logic       any_mode;
    logic [1:0] bs_taken, bs_not_taken;
    logic [4:0] pop_cnt;
    logic       else_flag;
    logic [1:0] stk_op;
    logic       ignore_uncov;
    logic [8:0] jump_addr;
    logic       jump_global;
    logic [8:0] prog_offset;
    logic [8:0] cur_pc;
    logic [3:0] alu_bits, pred_bits;
    logic       static_bool;
    logic [3:0] covered;
    logic [7:0] loop_count, loop_base;
    logic       res_valid, jump_taken, stack_err;
    logic [8:0] pc_next;
    logic [3:0] active_mask;
    logic [7:0] loop_reg;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic       take;
        logic [8:0] pc;
        logic [3:0] mask;
        logic [7:0] lreg;
        logic       err;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    simd_flow_ctl u0 (
        .clk(clk), .rst_n(rst_n), .fc_valid(fc_valid), .fc_op(fc_op),
        .jump_tbl(jump_tbl), .any_mode(any_mode), .bs_taken(bs_taken),
        .bs_not_taken(bs_not_taken), .pop_cnt(pop_cnt), .else_flag(else_flag),
        .stk_op(stk_op), .ignore_uncov(ignore_uncov), .jump_addr(jump_addr),
        .jump_global(jump_global), .prog_offset(prog_offset), .cur_pc(cur_pc),
        .alu_bits(alu_bits), .pred_bits(pred_bits), .static_bool(static_bool),
        .covered(covered), .loop_count(loop_count), .loop_base(loop_base),
        .res_valid(res_valid), .jump_taken(jump_taken), .pc_next(pc_next),
        .active_mask(active_mask), .loop_reg(loop_reg), .stack_err(stack_err)
    );

    task automatic set_defaults();
        fc_valid = 0; fc_op = 3'd0; jump_tbl = 8'h02; any_mode = 0;
        bs_taken = 2'd0; bs_not_taken = 2'd0; pop_cnt = 5'd0; else_flag = 0;
        stk_op = 2'd0; ignore_uncov = 0; jump_addr = 9'h000; jump_global = 1;
        prog_offset = 9'h000; cur_pc = 9'h000; alu_bits = 4'h0; pred_bits = 4'h0;
        static_bool = 1; covered = 4'hF; loop_count = 8'h00; loop_base = 8'h00;
    endtask

    task automatic check_bit(input string req, input string what,
                             input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_reset();
        @(negedge clk);
        check_bit("R1", "active_mask", 9'(active_mask), 9'hF);
        check_bit("R1", "stack_err", 9'(stack_err), 9'h0);
        check_bit("R1", "loop_reg", 9'(loop_reg), 9'h0);
        check_bit("R1", "res_valid", 9'(res_valid), 9'h0);
        check_bit("R1", "jump_taken", 9'(jump_taken), 9'h0);
        check_bit("R1", "pc_next", pc_next, 9'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // driver: one instruction per call, expected result into the scoreboard
    task automatic send(input logic e_take, input logic [8:0] e_pc,
                        input logic [3:0] e_mask, input logic [7:0] e_lreg,
                        input logic e_err, input string tag);
        exp_t e;
        @(negedge clk);
        fc_valid = 1;
        e.take = e_take; e.pc = e_pc; e.mask = e_mask;
        e.lreg = e_lreg; e.err = e_err; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
        fc_valid = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R8 unexpected result actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (jump_taken !== e.take || pc_next !== e.pc ||
                    active_mask !== e.mask || loop_reg !== e.lreg ||
                    stack_err !== e.err) begin
                    bad++;
                    $display("FAIL %s actual take=%b pc=%h mask=%b lreg=%h err=%b expected take=%b pc=%h mask=%b lreg=%h err=%b",
                             e.tag, jump_taken, pc_next, active_mask, loop_reg, stack_err,
                             e.take, e.pc, e.mask, e.lreg, e.err);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        set_defaults();
        do_reset();
        check_reset();

        // R2 all-vote, all wish, offset target
        jump_global = 0; jump_addr = 9'h010; prog_offset = 9'h005;
        send(1, 9'h015, 4'hF, 8'h00, 0, "R2");
        // R2 one pixel (index 5, table bit clear) refuses
        alu_bits = 4'b0001; cur_pc = 9'h020;
        send(0, 9'h021, 4'hF, 8'h00, 0, "R2");
        // R3 any-vote with the same wishes
        any_mode = 1; jump_global = 1; jump_addr = 9'h1F0;
        send(1, 9'h1F0, 4'hF, 8'h00, 0, "R3");
        // R8 target wrap
        any_mode = 0; alu_bits = 4'h0; jump_global = 0; jump_addr = 9'h1FE; prog_offset = 9'h005;
        send(1, 9'h003, 4'hF, 8'h00, 0, "R8");
        // R5 increment on taken: pixels 0,1 disagree and go inactive
        jump_global = 1; jump_addr = 9'h040; alu_bits = 4'b0011; any_mode = 1;
        bs_taken = 2'd2; cur_pc = 9'h030;
        send(1, 9'h040, 4'b1100, 8'h00, 0, "R5");
        // R4 only pixel 3 votes; pixel 2 disagrees and deactivates
        any_mode = 0; alu_bits = 4'b0100; covered = 4'b1000; ignore_uncov = 1;
        send(1, 9'h040, 4'b1000, 8'h00, 0, "R4");
        // R7 else swap: pixel 3 out, pixel 2 (counter 0) in
        covered = 4'hF; ignore_uncov = 0; alu_bits = 4'h0; bs_taken = 2'd0; else_flag = 1;
        send(1, 9'h040, 4'b0100, 8'h00, 0, "R7");
        else_flag = 0;
        // R6 decrement by 1: counters 1 reach 0 (stay), pixel 3 at 0 reactivates
        jump_tbl = 8'h00; bs_not_taken = 2'd1; pop_cnt = 5'd1; cur_pc = 9'h050;
        send(0, 9'h051, 4'b1100, 8'h00, 0, "R6");
        send(0, 9'h051, 4'hF, 8'h00, 0, "R6");
        // R3 no voters in any-mode
        bs_not_taken = 2'd0; pop_cnt = 5'd0; jump_tbl = 8'hFF; any_mode = 1;
        ignore_uncov = 1; covered = 4'h0;
        send(0, 9'h051, 4'hF, 8'h00, 0, "R3");
        // R2 no voters in all-mode
        any_mode = 0; jump_tbl = 8'h00; jump_addr = 9'h077;
        send(1, 9'h077, 4'hF, 8'h00, 0, "R2");
        covered = 4'hF; ignore_uncov = 0; jump_tbl = 8'h02;

        // R10 loop with count zero jumps
        fc_op = 3'd1; loop_count = 8'd0; jump_addr = 9'h060;
        send(1, 9'h060, 4'hF, 8'h00, 0, "R10");
        // R10 loop entered
        loop_count = 8'd2; loop_base = 8'h10; jump_tbl = 8'h00; cur_pc = 9'h070;
        send(0, 9'h071, 4'hF, 8'h10, 0, "R10");
        // R11 endloop iterations
        fc_op = 3'd2; jump_tbl = 8'h02; jump_addr = 9'h071;
        send(1, 9'h071, 4'hF, 8'h11, 0, "R11");
        cur_pc = 9'h080;
        send(0, 9'h081, 4'hF, 8'h00, 0, "R11");
        // R10 rep nested in loop keeps outer loop register
        fc_op = 3'd1; loop_count = 8'd3; loop_base = 8'h20; jump_tbl = 8'h00; cur_pc = 9'h090;
        send(0, 9'h091, 4'hF, 8'h20, 0, "R10");
        fc_op = 3'd3; loop_count = 8'd1; cur_pc = 9'h092;
        send(0, 9'h093, 4'hF, 8'h20, 0, "R10");
        // R11 endrep finishes, outer loop resumes
        fc_op = 3'd4; jump_tbl = 8'h02; cur_pc = 9'h094;
        send(0, 9'h095, 4'hF, 8'h20, 0, "R11");
        fc_op = 3'd2; jump_addr = 9'h091;
        send(1, 9'h091, 4'hF, 8'h21, 0, "R11");
        send(1, 9'h091, 4'hF, 8'h22, 0, "R11");
        send(0, 9'h095, 4'hF, 8'h00, 0, "R11");
        // R12 endloop on empty loop stack
        send(0, 9'h095, 4'hF, 8'h00, 1, "R12");

        repeat (3) @(negedge clk);
        set_defaults();
        do_reset();
        check_reset();

        // R9 pushes; the fifth overflows (R12)
        stk_op = 2'd2; jump_addr = 9'h010;
        for (int k = 1; k <= 5; k++) begin
            cur_pc = 9'(9'h100 + k);
            send(1, 9'h010, 4'hF, 8'h00, (k == 5), (k == 5) ? "R12" : "R9");
        end
        // R9 pops return the saved addresses, newest first
        stk_op = 2'd1; jump_addr = 9'h0AA;
        for (int k = 4; k >= 1; k--) begin
            send(1, 9'(9'h100 + k), 4'hF, 8'h00, 1, "R9");
        end
        // R12 pop on empty falls back to the computed target
        send(1, 9'h0AA, 4'hF, 8'h00, 1, "R12");

        repeat (4) @(negedge clk);
        check_bit("R8", "scoreboard left", 9'(sb.size()), 9'h0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule